// File: doc/BRIEF.md
# Aligned Indexed Vector Store Unit

This block executes one 128-bit vector store for a big-endian core. It accepts a 32-bit instruction word with its program counter and recognises two encodings. The short form names one of 32 vector registers. The wide form names one of 128 vector registers through an index that is split across two fields of the word. The unit puts the register indices on its read ports and samples the two 64-bit integer operands and the vector operand in the issue cycle.

The effective address is the integer base plus the integer index, cut to 32 bits, with its low four bits cleared. A base register index of zero means a literal zero. A misaligned address is quietly aligned and never faults. The vector goes out as a single 128-bit write with a valid/ready handshake. After the write is accepted, the unit reports completion with the next program counter. If reservation tracking is on and a reservation is live, it also pulses an invalidate carrying the written address. A word that matches neither encoding completes as illegal and produces no memory traffic.

Top module: `vstore_unit`

## Requirements
- R1: The short form is recognised when insn[31:26] is 31 and insn[10:1] is 231. Its source vector index is insn[25:21], zero-extended to 7 bits. insn[0] is ignored.
- R2: The wide form is recognised when insn[31:26] is 4, insn[10:4] is 7'h1C and insn[1:0] is 2'b11. Its 7-bit vector index is {insn[3:2], insn[25:21]}, so registers 0 to 127 can be named.
- R3: The base register index is insn[20:16] and the index register is insn[15:11]. When the base index is 0, the base value is zero, whatever register 0 holds.
- R4: mem_addr equals bits [31:0] of the 64-bit sum (base + index) with bits [3:0] forced to zero. Carries beyond bit 31 are dropped.
- R5: mem_wdata carries the byte for address mem_addr+k in bits [8k+7:8k]. The vector's most significant byte (bits 127:120) goes to address offset 0, and its least significant byte goes to offset 15.
- R6: A legal store raises mem_valid in the cycle after issue. mem_valid, mem_addr and mem_wdata hold unchanged until a cycle in which mem_ready is high. There is exactly one such write per store.
- R7: In the completion cycle, resv_inval is high, with resv_addr equal to mem_addr, exactly when resv_enable and resv_active were both high in the cycle the write was accepted.
- R8: A legal store asserts done with done_illegal low for exactly one cycle, the cycle after the write is accepted. In that cycle next_pc equals the issue PC plus 4.
- R9: A word that matches neither form asserts done and done_illegal in the cycle after issue. In that cycle next_pc equals the issue PC. No memory write and no invalidate are produced.
- R10: After reset, issue_ready is 1 while mem_valid and done are 0. issue_ready is 1 only while no store is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Unit idle, takes the offered instruction |
| issue_insn | input | 32 | Instruction word |
| issue_pc | input | PC_W | Program counter of the instruction |
| gpr_a_idx | output | 5 | Base register read index |
| gpr_a_data | input | GPR_W | Base register value |
| gpr_b_idx | output | 5 | Index register read index |
| gpr_b_data | input | GPR_W | Index register value |
| vreg_idx | output | 7 | Vector register read index |
| vreg_data | input | VEC_W | Vector register value |
| mem_valid | output | 1 | Write request pending |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Aligned write address |
| mem_wdata | output | VEC_W | Write data, byte k at address offset k |
| resv_enable | input | 1 | Reservation tracking switched on |
| resv_active | input | 1 | At least one reservation live |
| resv_inval | output | 1 | Invalidate reservations covering resv_addr |
| resv_addr | output | ADDR_W | Address for the invalidate |
| done | output | 1 | Instruction completed |
| done_illegal | output | 1 | Completed instruction was not recognised |
| next_pc | output | PC_W | Program counter after the instruction |

## Verification
The bench builds the unit with its default widths: 64-bit integer operands, a 128-bit vector and 32-bit address and PC. At these widths the 64-bit sum can carry past bit 31, which lets the bench test that the address is truncated. The full 7-bit wide-form index is also exercised, up to register 127. Random words of both forms and random illegal words run against random memory stalls. Directed cases cover a zero base index with register 0 non-zero, misaligned sums, the carry wrap, and all four combinations of the reservation inputs.

// File: rtl/vst_pkg.sv
package vst_pkg;
    localparam int INSN_W   = 32;
    localparam int RIDX_W   = 5;
    localparam int VIDX_W   = 7;

    localparam logic [5:0] OP_SHORT   = 6'd31;
    localparam logic [9:0] XO_SHORT   = 10'd231;
    localparam logic [5:0] OP_WIDE    = 6'd4;
    localparam logic [6:0] XO_WIDE    = 7'h1C;
    localparam logic [1:0] TAIL_WIDE  = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_RESP  = 2'd2
    } vst_state_e;
endpackage

// File: rtl/vst_decode.sv
module vst_decode
    import vst_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output logic              legal,
    output logic [RIDX_W-1:0] ra_idx,
    output logic [RIDX_W-1:0] rb_idx,
    output logic [VIDX_W-1:0] vs_idx
);
    logic is_short;
    logic is_wide;

    always_comb begin
        is_short = (insn[31:26] == OP_SHORT) && (insn[10:1] == XO_SHORT);
        is_wide  = (insn[31:26] == OP_WIDE) && (insn[10:4] == XO_WIDE)
                   && (insn[1:0] == TAIL_WIDE);
        legal    = is_short || is_wide;
        ra_idx   = insn[20:16];
        rb_idx   = insn[15:11];
        if (is_wide) begin
            vs_idx = {insn[3:2], insn[25:21]};
        end else begin
            vs_idx = {2'b00, insn[25:21]};
        end
    end
endmodule

// File: rtl/vst_agen.sv
module vst_agen
    import vst_pkg::*;
#(
    parameter int GPR_W      = 64,
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 4
) (
    input  logic [RIDX_W-1:0] ra_idx,
    input  logic [GPR_W-1:0]  base_val,
    input  logic [GPR_W-1:0]  index_val,
    output logic [ADDR_W-1:0] ea
);
    logic [GPR_W-1:0] base_eff;
    logic [GPR_W-1:0] sum;

    always_comb begin
        base_eff = (ra_idx == '0) ? '0 : base_val;
        sum      = base_eff + index_val;
        ea       = {sum[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end
endmodule

// File: rtl/vst_lanes.sv
module vst_lanes #(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] vec_in,
    output logic [VEC_W-1:0] bus_out
);
    localparam int NBYTES = VEC_W / 8;

    for (genvar k = 0; k < NBYTES; k++) begin : g_lane
        assign bus_out[8*k +: 8] = vec_in[VEC_W-1-8*k -: 8];
    end
endmodule

// File: rtl/vstore_unit.sv
module vstore_unit
    import vst_pkg::*;
#(
    parameter int GPR_W  = 64,
    parameter int VEC_W  = 128,
    parameter int ADDR_W = 32,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  logic [31:0]       issue_insn,
    input  logic [PC_W-1:0]   issue_pc,
    output logic [4:0]        gpr_a_idx,
    input  logic [GPR_W-1:0]  gpr_a_data,
    output logic [4:0]        gpr_b_idx,
    input  logic [GPR_W-1:0]  gpr_b_data,
    output logic [6:0]        vreg_idx,
    input  logic [VEC_W-1:0]  vreg_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [VEC_W-1:0]  mem_wdata,
    input  logic              resv_enable,
    input  logic              resv_active,
    output logic              resv_inval,
    output logic [ADDR_W-1:0] resv_addr,
    output logic              done,
    output logic              done_illegal,
    output logic [PC_W-1:0]   next_pc
);
    localparam int NBYTES     = VEC_W / 8;
    localparam int ALIGN_BITS = $clog2(NBYTES);
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

    typedef struct packed {
        vst_state_e        st;
        logic [ADDR_W-1:0] ea;
        logic [VEC_W-1:0]  data;
        logic [PC_W-1:0]   pc_next;
        logic              illegal;
        logic              inval;
    } vst_regs_t;

    vst_regs_t r_q, r_d;

    logic              dec_legal;
    logic [RIDX_W-1:0] dec_ra, dec_rb;
    logic [VIDX_W-1:0] dec_vs;
    logic [ADDR_W-1:0] agen_ea;
    logic [VEC_W-1:0]  lane_data;

    vst_decode u_dec (
        .insn   (issue_insn),
        .legal  (dec_legal),
        .ra_idx (dec_ra),
        .rb_idx (dec_rb),
        .vs_idx (dec_vs)
    );

    vst_agen #(
        .GPR_W      (GPR_W),
        .ADDR_W     (ADDR_W),
        .ALIGN_BITS (ALIGN_BITS)
    ) u_agen (
        .ra_idx    (dec_ra),
        .base_val  (gpr_a_data),
        .index_val (gpr_b_data),
        .ea        (agen_ea)
    );

    vst_lanes #(
        .VEC_W (VEC_W)
    ) u_lanes (
        .vec_in  (vreg_data),
        .bus_out (lane_data)
    );

    assign gpr_a_idx = dec_ra;
    assign gpr_b_idx = dec_rb;
    assign vreg_idx  = dec_vs;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.inval = 1'b0;
                if (issue_valid) begin
                    if (dec_legal) begin
                        r_d.st      = ST_WRITE;
                        r_d.ea      = agen_ea;
                        r_d.data    = lane_data;
                        r_d.pc_next = issue_pc + PC_STEP;
                        r_d.illegal = 1'b0;
                    end else begin
                        r_d.st      = ST_RESP;
                        r_d.pc_next = issue_pc;
                        r_d.illegal = 1'b1;
                    end
                end
            end
            ST_WRITE: begin
                if (mem_ready) begin
                    r_d.st    = ST_RESP;
                    r_d.inval = resv_enable && resv_active;
                end
            end
            ST_RESP: begin
                r_d.st      = ST_IDLE;
                r_d.inval   = 1'b0;
                r_d.illegal = 1'b0;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ea: '0, data: '0, pc_next: '0,
                     illegal: 1'b0, inval: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign issue_ready  = (r_q.st == ST_IDLE);
    assign mem_valid    = (r_q.st == ST_WRITE);
    assign mem_addr     = r_q.ea;
    assign mem_wdata    = r_q.data;
    assign done         = (r_q.st == ST_RESP);
    assign done_illegal = done && r_q.illegal;
    assign next_pc      = r_q.pc_next;
    assign resv_inval   = done && r_q.inval;
    assign resv_addr    = r_q.ea;

    // R6
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata));

    // R4
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[ALIGN_BITS-1:0] == '0));

    // R8
    write_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> done && !done_illegal);

    // R9
    illegal_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_illegal |-> $past(issue_valid && issue_ready) && !resv_inval);

    // R10
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !issue_ready);

    // R7
    inval_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resv_inval |-> done && !done_illegal && (resv_addr[ALIGN_BITS-1:0] == '0));
endmodule

// File: tb/vstore_unit_test.sv
`timescale 1ns/1ps
module vstore_unit_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue_valid = 1'b0;
    logic         issue_ready;
    logic [31:0]  issue_insn = '0;
    logic [31:0]  issue_pc = '0;
    logic [4:0]   gpr_a_idx, gpr_b_idx;
    logic [63:0]  gpr_a_data, gpr_b_data;
    logic [6:0]   vreg_idx;
    logic [127:0] vreg_data;
    logic         mem_valid;
    logic         mem_ready = 1'b0;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         resv_enable = 1'b0;
    logic         resv_active = 1'b0;
    logic         resv_inval;
    logic [31:0]  resv_addr;
    logic         done, done_illegal;
    logic [31:0]  next_pc;

    logic [63:0]  gpr [32];
    logic [127:0] vr  [128];

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    assign gpr_a_data = gpr[gpr_a_idx];
    assign gpr_b_data = gpr[gpr_b_idx];
    assign vreg_data  = vr[vreg_idx];

    vstore_unit uut (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_insn(issue_insn), .issue_pc(issue_pc),
        .gpr_a_idx(gpr_a_idx), .gpr_a_data(gpr_a_data),
        .gpr_b_idx(gpr_b_idx), .gpr_b_data(gpr_b_data),
        .vreg_idx(vreg_idx), .vreg_data(vreg_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .resv_enable(resv_enable), .resv_active(resv_active),
        .resv_inval(resv_inval), .resv_addr(resv_addr),
        .done(done), .done_illegal(done_illegal), .next_pc(next_pc)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_legal(input logic [31:0] w);
        bit s = (w[31:26] == 6'd31) && (w[10:1] == 10'd231);
        bit x = (w[31:26] == 6'd4) && (w[10:4] == 7'h1C) && (w[1:0] == 2'b11);
        return s || x;
    endfunction

    function automatic logic [6:0] exp_vidx(input logic [31:0] w);
        if (w[31:26] == 6'd4) return {w[3:2], w[25:21]};
        return {2'b00, w[25:21]};
    endfunction

    function automatic logic [31:0] exp_ea(input logic [31:0] w);
        logic [63:0] base = (w[20:16] == 5'd0) ? 64'd0 : gpr[w[20:16]];
        logic [63:0] s = base + gpr[w[15:11]];
        return s[31:0] & 32'hFFFF_FFF0;
    endfunction

    function automatic logic [127:0] exp_bus(input logic [127:0] v);
        logic [127:0] b;
        for (int k = 0; k < 16; k++) b[8*k +: 8] = v[127-8*k -: 8];
        return b;
    endfunction

    function automatic logic [31:0] mk_short(input logic [4:0] vs, input logic [4:0] ra,
                                             input logic [4:0] rb, input bit rc);
        return {6'd31, vs, ra, rb, 10'd231, rc};
    endfunction

    function automatic logic [31:0] mk_wide(input logic [6:0] vs, input logic [4:0] ra,
                                            input logic [4:0] rb);
        return {6'd4, vs[4:0], ra, rb, 7'h1C, vs[6:5], 2'b11};
    endfunction

    task automatic run_one(input logic [31:0] w, input logic [31:0] pc,
                           input bit en, input bit act, input int stall);
        bit          lg  = exp_legal(w);
        logic [31:0] ea  = exp_ea(w);
        logic [127:0] bus = exp_bus(vr[exp_vidx(w)]);
        @(negedge clk);
        chk(issue_ready == 1'b1, "R10 ready when idle", 128'(issue_ready), 128'd1);
        issue_valid = 1'b1; issue_insn = w; issue_pc = pc;
        resv_enable = en; resv_active = act; mem_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        issue_valid = 1'b0;
        if (!lg) begin
            // R9
            chk(done && done_illegal, "R9 illegal done", {done, done_illegal}, 2'b11);
            chk(next_pc == pc, "R9 pc held", 128'(next_pc), 128'(pc));
            chk(!mem_valid && !resv_inval, "R9 no write", {mem_valid, resv_inval}, 2'b00);
            @(posedge clk);
            return;
        end
        for (int c = 0; c < 64; c++) begin
            // R1 R2 R3 R4 via address and data; R6 hold each cycle
            chk(mem_valid == 1'b1, "R6 valid held", 128'(mem_valid), 128'd1);
            chk(mem_addr == ea, "R4 address", 128'(mem_addr), 128'(ea));
            chk(mem_wdata == bus, "R5 lane data", mem_wdata, bus);
            chk(!done, "R8 no early done", 128'(done), 128'd0);
            mem_ready = (c >= stall);
            @(posedge clk);
            if (mem_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        mem_ready = 1'b0;
        chk(done && !done_illegal, "R8 done legal", {done, done_illegal}, 2'b10);
        chk(next_pc == pc + 32'd4, "R8 pc+4", 128'(next_pc), 128'(pc + 32'd4));
        chk(!mem_valid, "R6 single write", 128'(mem_valid), 128'd0);
        chk(resv_inval == (en && act), "R7 invalidate", 128'(resv_inval), 128'(en && act));
        if (en && act)
            chk(resv_addr == ea, "R7 invalidate address", 128'(resv_addr), 128'(ea));
        @(posedge clk);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) gpr[i] = {$urandom, $urandom};
        for (int i = 0; i < 128; i++) vr[i] = {$urandom, $urandom, $urandom, $urandom};
        gpr[0] = 64'h1234_5678_9ABC_DEF7;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(issue_ready && !mem_valid && !done, "R10 reset state",
            {issue_ready, mem_valid, done}, 3'b100);
        rst_n = 1'b1;

        // R3: base index 0 ignores register 0
        gpr[6] = 64'h0000_0000_0000_1237;
        run_one(mk_short(5'd3, 5'd0, 5'd6, 1'b0), 32'h100, 1'b0, 1'b0, 0);
        // R4: carry beyond bit 31 dropped
        gpr[7] = 64'hFFFF_FFFF_FFFF_FFFF; gpr[8] = 64'h20;
        run_one(mk_short(5'd9, 5'd7, 5'd8, 1'b1), 32'h104, 1'b1, 1'b1, 3);
        // R2: highest and mid wide indices
        run_one(mk_wide(7'd127, 5'd4, 5'd5), 32'h108, 1'b1, 1'b0, 1);
        run_one(mk_wide(7'd64, 5'd0, 5'd9), 32'h10C, 1'b0, 1'b1, 8);
        run_one(mk_wide(7'd33, 5'd2, 5'd3), 32'h110, 1'b1, 1'b1, 0);
        // R1: bit 0 ignored
        run_one(mk_short(5'd31, 5'd1, 5'd1, 1'b1), 32'h114, 1'b0, 1'b0, 2);
        // R9: near misses
        run_one({6'd4, 5'd1, 5'd2, 5'd3, 7'h1C, 2'b00, 2'b00}, 32'h118, 1'b1, 1'b1, 0);
        run_one({6'd31, 5'd1, 5'd2, 5'd3, 10'd230, 1'b0}, 32'h11C, 1'b1, 1'b1, 0);
        run_one(32'h0000_0000, 32'h120, 1'b0, 1'b0, 0);

        for (int n = 0; n < 400; n++) begin
            int sel = $urandom % 5;
            if (sel < 2)
                w = mk_short(5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom));
            else if (sel < 4)
                w = mk_wide(7'($urandom), 5'($urandom), 5'($urandom));
            else begin
                w = $urandom;
                if (exp_legal(w)) w[0] = ~w[0] ^ (w[31:26] == 6'd31);
            end
            run_one(w, $urandom & 32'hFFFF_FFFC, 1'($urandom), 1'($urandom),
                    int'($urandom % 5));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule